// File: doc/BRIEF.md
# Network Message Packetizer

The packetizer turns one message into a series of framed network segments. A control stream supplies three values for each message: a destination, a total byte count and a tag. The payload then arrives as 512-bit stream beats. The block opens every segment with a one-beat application header. It then passes payload beats through until the segment's share of the message has been sent, and it raises TLAST on the segment's final beat. When the last segment of the message has left, the block places the message tag on a status stream.

The segment size comes from an MTU value held in a small write-only register. The register is normally written once for each collective operation. The MTU covers the header beat plus the payload, and payload is always cut on whole 64-byte beats, so the block never has to shift data between beats. The block copies the MTU-derived limit when it accepts a command. A register write made while a message is in progress therefore takes effect from the next message.

Top module: `msg_packetizer`

## Requirements
- R1: After reset, cmd_ready is 1, and out_tvalid, sts_valid and in_tready are 0. The MTU register resets to DEFAULT_MTU, which is 1536 bytes.
- R2: Each segment starts with a header beat with TKEEP all ones. The header carries the destination in bits [31:0], the segment's payload byte count in [63:32], the tag in [95:64], and zero in all other bits. A header beat held by backpressure keeps its value.
- R3: Segment payload limit = the largest multiple of 64 that is no more than MTU-64, with a minimum of 64 bytes (an MTU below 128 acts as 128). Every segment carries the limit or, for the final segment, whatever remains.
- R4: TLAST is 1 on the last data beat of each segment and on no other data beat. A segment of N payload bytes has ceil(N/64) data beats.
- R5: TKEEP is all ones on data beats, except the final beat of a segment whose byte count is not a multiple of 64. On that beat, TKEEP bit i is 1 only for i < (count mod 64).
- R6: A command with byte count 0 produces one header beat with count 0 and TLAST 1, followed by a status word.
- R7: In the cycle after the last beat of the message is accepted, sts_valid rises with sts_tag equal to the command tag. Both hold until sts_ready is seen.
- R8: Under output backpressure and input gaps, payload beats come out in order, with none lost and none duplicated.
- R9: The MTU limit is captured when the command is accepted. An MTU write during a message changes only later messages.
- R10: cmd_ready is 1 only while the block is idle, that is, from the cycle after the status word is taken until the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mtu_we | input | 1 | MTU register write strobe |
| cfg_mtu_wdata | input | 16 | MTU value in bytes |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_dest | input | 32 | Message destination |
| cmd_bytes | input | 32 | Message byte count |
| cmd_tag | input | 32 | Message tag |
| in_tvalid | input | 1 | Payload beat valid |
| in_tready | output | 1 | Payload beat ready |
| in_tdata | input | 512 | Payload beat data |
| out_tvalid | output | 1 | Segment beat valid |
| out_tready | input | 1 | Segment beat ready |
| out_tdata | output | 512 | Header or payload data |
| out_tkeep | output | 64 | Byte enables |
| out_tlast | output | 1 | Last beat of a segment |
| sts_valid | output | 1 | Completion status valid |
| sts_ready | input | 1 | Completion status ready |
| sts_tag | output | 32 | Tag of the completed message |

## Verification
The header of the first segment becomes valid one cycle after the command is accepted, and each later header one cycle after the previous segment's last beat. Payload beats pass through in the same cycle, so out_tvalid and in_tready follow the handshake partners combinationally. The status word is due exactly one cycle after the final beat is accepted, and cmd_ready returns one cycle after the status is taken. The bench drives inputs on the falling edge and samples 1 ns later. It checks the status and idle results at those exact cycles, and it polls the handshake for every beat, so no expected beat can be skipped or counted twice.

// File: rtl/pktz_pkg.sv
package pktz_pkg;
  localparam int DATA_W  = 512;
  localparam int KEEP_W  = DATA_W / 8;
  localparam int BEAT_B  = KEEP_W;
  localparam int BEAT_SH = $clog2(BEAT_B);
  localparam int LEN_W   = 32;
  localparam int MTU_W   = 16;
  localparam int HDR_W   = 3 * LEN_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_DATA = 2'd2,
    ST_STS  = 2'd3
  } fr_state_e;

  // payload bytes allowed per segment: header beat included in MTU
  function automatic logic [LEN_W-1:0] seg_limit(input logic [MTU_W-1:0] mtu);
    logic [LEN_W-1:0] m;
    m = LEN_W'(mtu);
    if (m < LEN_W'(2 * BEAT_B)) return LEN_W'(BEAT_B);
    return ((m - LEN_W'(BEAT_B)) >> BEAT_SH) << BEAT_SH;
  endfunction

  function automatic logic [LEN_W-1:0] beats_of(input logic [LEN_W-1:0] len);
    logic [LEN_W:0] t;
    t = {1'b0, len} + (LEN_W+1)'(BEAT_B - 1);
    return LEN_W'(t >> BEAT_SH);
  endfunction

  function automatic logic [KEEP_W-1:0] tail_keep(input logic [LEN_W-1:0] len);
    logic [BEAT_SH-1:0] n;
    n = len[BEAT_SH-1:0];
    if (n == '0) return '1;
    return (KEEP_W'(1) << n) - KEEP_W'(1);
  endfunction

  function automatic logic [LEN_W-1:0] min_len(input logic [LEN_W-1:0] a,
                                                input logic [LEN_W-1:0] b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/pktz_mtu_cfg.sv
module pktz_mtu_cfg
  import pktz_pkg::*;
#(
  parameter int RST_MTU = 1536
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [MTU_W-1:0] wdata,
  output logic [LEN_W-1:0] limit
);
  logic [MTU_W-1:0] mtu_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  mtu_q <= MTU_W'(RST_MTU);
    else if (we) mtu_q <= wdata;
  end

  assign limit = seg_limit(mtu_q);
endmodule

// File: rtl/pktz_seg_calc.sv
module pktz_seg_calc
  import pktz_pkg::*;
(
  input  logic [LEN_W-1:0] remaining,
  input  logic [LEN_W-1:0] limit,
  output logic [LEN_W-1:0] seg_len,
  output logic [LEN_W-1:0] left_after,
  output logic [LEN_W-1:0] seg_beats
);
  always_comb begin
    seg_len    = min_len(remaining, limit);
    left_after = remaining - seg_len;
    seg_beats  = beats_of(seg_len);
  end
endmodule

// File: rtl/pktz_framer.sv
module pktz_framer
  import pktz_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  cfg_limit,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [LEN_W-1:0]  cmd_dest,
  input  logic [LEN_W-1:0]  cmd_bytes,
  input  logic [LEN_W-1:0]  cmd_tag,
  input  logic              in_tvalid,
  output logic              in_tready,
  input  logic [DATA_W-1:0] in_tdata,
  output logic              out_tvalid,
  input  logic              out_tready,
  output logic [DATA_W-1:0] out_tdata,
  output logic [KEEP_W-1:0] out_tkeep,
  output logic              out_tlast,
  output logic              sts_valid,
  input  logic              sts_ready,
  output logic [LEN_W-1:0]  sts_tag,
  output logic [LEN_W-1:0]  calc_rem,
  output logic [LEN_W-1:0]  calc_lim,
  input  logic [LEN_W-1:0]  calc_seg,
  input  logic [LEN_W-1:0]  calc_left,
  input  logic [LEN_W-1:0]  calc_beats
);
  fr_state_e        state_q;
  logic [LEN_W-1:0] dest_q, tag_q, rem_q, seg_len_q, beats_left_q, limit_q;
  logic [LEN_W-1:0] data_cnt_q;

  // named events
  logic cmd_take, hdr_fire, data_fire, seg_end, msg_end, sts_take;

  assign cmd_take  = (state_q == ST_IDLE) && cmd_valid;
  assign hdr_fire  = (state_q == ST_HDR) && out_tready;
  assign data_fire = (state_q == ST_DATA) && in_tvalid && out_tready;
  assign seg_end   = data_fire && (beats_left_q == LEN_W'(1));
  assign msg_end   = (seg_end && (rem_q == '0)) || (hdr_fire && (seg_len_q == '0));
  assign sts_take  = (state_q == ST_STS) && sts_ready;

  // segment calculator input: new command or remainder of current one
  assign calc_rem = (state_q == ST_IDLE) ? cmd_bytes : rem_q;
  assign calc_lim = (state_q == ST_IDLE) ? cfg_limit : limit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      dest_q       <= '0;
      tag_q        <= '0;
      rem_q        <= '0;
      seg_len_q    <= '0;
      beats_left_q <= '0;
      limit_q      <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cmd_take) begin
          dest_q       <= cmd_dest;
          tag_q        <= cmd_tag;
          limit_q      <= cfg_limit;
          seg_len_q    <= calc_seg;
          rem_q        <= calc_left;
          beats_left_q <= calc_beats;
          state_q      <= ST_HDR;
        end
        ST_HDR: if (hdr_fire) begin
          state_q <= (seg_len_q == '0) ? ST_STS : ST_DATA;
        end
        ST_DATA: if (data_fire) begin
          beats_left_q <= beats_left_q - LEN_W'(1);
          if (seg_end) begin
            if (rem_q == '0) begin
              state_q <= ST_STS;
            end else begin
              seg_len_q    <= calc_seg;
              rem_q        <= calc_left;
              beats_left_q <= calc_beats;
              state_q      <= ST_HDR;
            end
          end
        end
        ST_STS: if (sts_take) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // data beats seen since the last header, for the checks
  always_ff @(posedge clk) begin
    if (!rst_n)        data_cnt_q <= '0;
    else if (hdr_fire) data_cnt_q <= '0;
    else if (data_fire) data_cnt_q <= data_cnt_q + LEN_W'(1);
  end

  always_comb begin
    cmd_ready  = (state_q == ST_IDLE);
    sts_valid  = (state_q == ST_STS);
    sts_tag    = tag_q;
    in_tready  = (state_q == ST_DATA) && out_tready;
    out_tvalid = 1'b0;
    out_tdata  = '0;
    out_tkeep  = '1;
    out_tlast  = 1'b0;
    if (state_q == ST_HDR) begin
      out_tvalid = 1'b1;
      out_tdata  = {{(DATA_W-HDR_W){1'b0}}, tag_q, seg_len_q, dest_q};
      out_tlast  = (seg_len_q == '0);
    end else if (state_q == ST_DATA) begin
      out_tvalid = in_tvalid;
      out_tdata  = in_tdata;
      out_tlast  = (beats_left_q == LEN_W'(1));
      out_tkeep  = out_tlast ? tail_keep(seg_len_q) : '1;
    end
  end

  // R10
  cmd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!out_tvalid && !sts_valid && !in_tready));

  // R7
  sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_valid && !sts_ready) |=> (sts_valid && $stable(sts_tag)));

  // R7
  sts_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_end |=> sts_valid);

  // R3
  seg_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> (seg_len_q <= limit_q));

  // R4
  seg_beats_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_fire && out_tlast) |-> ((data_cnt_q + LEN_W'(1)) == beats_of(seg_len_q)));

  // R2
  hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_HDR) && !out_tready) |=> (out_tvalid && $stable(out_tdata)));

  // R9
  lim_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> ((state_q == ST_IDLE) || $stable(limit_q)));
endmodule

// File: rtl/msg_packetizer.sv
module msg_packetizer
  import pktz_pkg::*;
#(
  parameter int DEFAULT_MTU = 1536
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_mtu_we,
  input  logic [MTU_W-1:0]  cfg_mtu_wdata,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [LEN_W-1:0]  cmd_dest,
  input  logic [LEN_W-1:0]  cmd_bytes,
  input  logic [LEN_W-1:0]  cmd_tag,
  input  logic              in_tvalid,
  output logic              in_tready,
  input  logic [DATA_W-1:0] in_tdata,
  output logic              out_tvalid,
  input  logic              out_tready,
  output logic [DATA_W-1:0] out_tdata,
  output logic [KEEP_W-1:0] out_tkeep,
  output logic              out_tlast,
  output logic              sts_valid,
  input  logic              sts_ready,
  output logic [LEN_W-1:0]  sts_tag
);
  logic [LEN_W-1:0] cfg_limit, calc_rem, calc_lim, calc_seg, calc_left, calc_beats;

  pktz_mtu_cfg #(.RST_MTU(DEFAULT_MTU)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_mtu_we),
    .wdata (cfg_mtu_wdata),
    .limit (cfg_limit)
  );

  pktz_seg_calc u_calc (
    .remaining  (calc_rem),
    .limit      (calc_lim),
    .seg_len    (calc_seg),
    .left_after (calc_left),
    .seg_beats  (calc_beats)
  );

  pktz_framer u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_limit  (cfg_limit),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_dest   (cmd_dest),
    .cmd_bytes  (cmd_bytes),
    .cmd_tag    (cmd_tag),
    .in_tvalid  (in_tvalid),
    .in_tready  (in_tready),
    .in_tdata   (in_tdata),
    .out_tvalid (out_tvalid),
    .out_tready (out_tready),
    .out_tdata  (out_tdata),
    .out_tkeep  (out_tkeep),
    .out_tlast  (out_tlast),
    .sts_valid  (sts_valid),
    .sts_ready  (sts_ready),
    .sts_tag    (sts_tag),
    .calc_rem   (calc_rem),
    .calc_lim   (calc_lim),
    .calc_seg   (calc_seg),
    .calc_left  (calc_left),
    .calc_beats (calc_beats)
  );
endmodule

// File: tb/msg_packetizer_test.sv
`timescale 1ns/1ps
module msg_packetizer_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_mtu_we = 1'b0;
  logic [15:0]  cfg_mtu_wdata = '0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [31:0]  cmd_dest = '0, cmd_bytes = '0, cmd_tag = '0;
  logic         in_tvalid = 1'b0;
  logic         in_tready;
  logic [511:0] in_tdata = '0;
  logic         out_tvalid;
  logic         out_tready = 1'b1;
  logic [511:0] out_tdata;
  logic [63:0]  out_tkeep;
  logic         out_tlast;
  logic         sts_valid;
  logic         sts_ready = 1'b0;
  logic [31:0]  sts_tag;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  msg_packetizer uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_mtu_we(cfg_mtu_we), .cfg_mtu_wdata(cfg_mtu_wdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_dest(cmd_dest), .cmd_bytes(cmd_bytes), .cmd_tag(cmd_tag),
    .in_tvalid(in_tvalid), .in_tready(in_tready), .in_tdata(in_tdata),
    .out_tvalid(out_tvalid), .out_tready(out_tready), .out_tdata(out_tdata),
    .out_tkeep(out_tkeep), .out_tlast(out_tlast),
    .sts_valid(sts_valid), .sts_ready(sts_ready), .sts_tag(sts_tag)
  );

  task automatic check(input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected limit, found by stepping up in whole beats
  function automatic int exp_limit(input int mtu);
    int l = 64;
    while (l + 128 <= mtu) l += 64;
    return l;
  endfunction

  function automatic logic [511:0] pat(input int tag, input int idx);
    logic [511:0] p;
    for (int k = 0; k < 16; k++) p[k*32 +: 32] = tag * 4096 + idx * 16 + k;
    return p;
  endfunction

  task automatic write_mtu(input int mtu);
    @(negedge clk); cfg_mtu_we = 1'b1; cfg_mtu_wdata = 16'(mtu);
    @(negedge clk); cfg_mtu_we = 1'b0;
  endtask

  task automatic get_beat(input bit bp);
    bit ok = 0;
    while (!ok) begin
      @(negedge clk);
      out_tready = bp ? (cyc % 3 != 1) : 1'b1;
      #1;
      ok = out_tvalid && out_tready;
    end
  endtask

  // one message: command, payload, segment checks, status
  task automatic run_msg(input int dest, input int nbytes, input int tag, input int lim,
                         input bit bp, input bit gap, input int mid_mtu, input int sts_delay);
    int nb = (nbytes + 63) / 64;
    fork
      begin
        @(negedge clk);
        cmd_valid = 1'b1; cmd_dest = dest; cmd_bytes = nbytes; cmd_tag = tag;
        #1;
        while (!cmd_ready) begin @(negedge clk); #1; end
        @(negedge clk); cmd_valid = 1'b0;
      end
      begin
        int idx = 0;
        while (idx < nb) begin
          @(negedge clk); in_tvalid = 1'b1; in_tdata = pat(tag, idx);
          #1;
          if (in_tready) begin
            idx++;
            if (gap && (idx % 2 == 1)) begin @(negedge clk); in_tvalid = 1'b0; end
          end
        end
        @(negedge clk); in_tvalid = 1'b0;
      end
      begin
        if (mid_mtu != 0) begin
          repeat (4) @(negedge clk);
          cfg_mtu_we = 1'b1; cfg_mtu_wdata = 16'(mid_mtu);
          @(negedge clk); cfg_mtu_we = 1'b0;
        end
      end
      begin
        int rem = nbytes;
        int didx = 0;
        bit first = 1;
        while (first || rem > 0) begin
          int seg = (rem < lim) ? rem : lim;
          int sb = (seg + 63) / 64;
          first = 0;
          get_beat(bp);
          // R2 header layout, R3 segment size, R6 zero-length header
          check("R2/R3 header data", out_tdata, {416'b0, 32'(tag), 32'(seg), 32'(dest)});
          check("R2 header keep", 512'(out_tkeep), 512'({64{1'b1}}));
          check("R4/R6 header last", 512'(out_tlast), 512'(seg == 0));
          check("R10 busy cmd_ready", 512'(cmd_ready), 512'(0));
          for (int b = 0; b < sb; b++) begin
            logic [63:0] ek = '1;
            if (b == sb - 1) begin
              int nbb = seg - (sb - 1) * 64;
              ek = '0;
              for (int i = 0; i < nbb; i++) ek[i] = 1'b1;
            end
            get_beat(bp);
            check("R8 payload order", out_tdata, pat(tag, didx));
            check("R4 data last", 512'(out_tlast), 512'(b == sb - 1));
            check("R5 data keep", 512'(out_tkeep), 512'(ek));
            didx++;
          end
          rem -= seg;
        end
        @(negedge clk); out_tready = 1'b1; #1;
        check("R7 status due", 512'(sts_valid), 512'(1));
        for (int d = 0; d < sts_delay; d++) begin
          check("R7 status tag held", 512'(sts_tag), 512'(tag));
          check("R10 no cmd while status", 512'(cmd_ready), 512'(0));
          @(negedge clk); #1;
          check("R7 status held", 512'(sts_valid), 512'(1));
        end
        sts_ready = 1'b1;
        check("R7 status tag", 512'(sts_tag), 512'(tag));
        @(negedge clk); sts_ready = 1'b0; #1;
        check("R10 idle after status", 512'(cmd_ready), 512'(1));
        check("R7 status cleared", 512'(sts_valid), 512'(0));
      end
    join
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    check("R1 cmd_ready", 512'(cmd_ready), 512'(1));
    check("R1 out_tvalid", 512'(out_tvalid), 512'(0));
    check("R1 sts_valid", 512'(sts_valid), 512'(0));
    check("R1 in_tready", 512'(in_tready), 512'(0));
  endtask

  // R1 default MTU 1536: segments 1472,1472,56
  task automatic t_default_mtu();
    run_msg(32'h11, 3000, 1, exp_limit(1536), 0, 0, 0, 0);
  endtask

  // R3 clamp: MTU 100 acts as 128, limit 64
  task automatic t_small_mtu();
    write_mtu(100);
    run_msg(32'h22, 200, 2, 64, 0, 0, 0, 0);
  endtask

  // R5 exact multiple: all keep ones
  task automatic t_exact();
    write_mtu(320);
    run_msg(32'h33, 512, 3, exp_limit(320), 0, 0, 0, 0);
  endtask

  // R6 zero-byte command
  task automatic t_zero();
    run_msg(32'h44, 0, 4, exp_limit(320), 0, 0, 0, 1);
  endtask

  // R8 backpressure and input gaps
  task automatic t_backpressure();
    write_mtu(256);
    run_msg(32'h55, 700, 5, exp_limit(256), 1, 1, 0, 0);
  endtask

  // R9 MTU change during a message applies to next one
  task automatic t_mid_change();
    write_mtu(576);
    run_msg(32'h66, 1200, 6, exp_limit(576), 0, 0, 192, 0);
    run_msg(32'h77, 300, 7, exp_limit(192), 0, 0, 0, 0);
  endtask

  // R7 status held under sts_ready low
  task automatic t_status_hold();
    run_msg(32'h88, 65, 8, exp_limit(192), 1, 0, 0, 4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_default_mtu();
    t_small_mtu();
    t_exact();
    t_zero();
    t_backpressure();
    t_mid_change();
    t_status_hold();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule